// File: doc/BRIEF.md
# Hierarchical Carry Lookahead Adder

This block adds two 16-bit unsigned or two's-complement operands and a carry-in. It returns the 16-bit sum and the carry-out. The operands are split into four 4-bit slices. Each slice forms a generate term and a propagate term for every bit. It then derives all of its internal carries as flat two-level sums of products, with no bit-to-bit ripple.

Each slice also reports a group propagate and a group generate. A second-level lookahead unit combines these four pairs with the carry-in. It produces the carry into each upper slice and the final carry-out, using the same flattened equations one level up. It also exports a whole-word group propagate and group generate, so the adder can itself feed a wider lookahead tree.

With unit gate delays, the carry into the top slice settles after about 5 delays and the top sum after about 8. A bit-serial ripple needs about 32. The block is purely combinational and holds no state.

Top module: `cla_adder16`

## Requirements
- R1: `sum_o` equals the low 16 bits of `a_i + b_i + c_i`, taken as unsigned integers.
- R2: `c_o` equals bit 16 of the 17-bit result of `a_i + b_i + c_i`.
- R3: `grp_p_o` is 1 exactly when every bit of `a_i XOR b_i` is 1.
- R4: `grp_g_o` is 1 exactly when `a_i + b_i`, with no carry-in, exceeds 16'hFFFF. Its value does not depend on `c_i`.
- R5: `c_o` equals `grp_g_o OR (grp_p_o AND c_i)`.
- R6: `grp_p_o` and `grp_g_o` are never 1 at the same time.
- R7: When every bit propagates and `c_i` is 1, the carry travels the full chain. In that case `sum_o` is 16'h0000 and `c_o` is 1; for example, 16'hFFFF + 16'h0000 + 1 and 16'hAAAA + 16'h5555 + 1.
- R8: A carry generated in one slice reaches the slices above it. For example, 16'hFFFF + 16'h0001 with carry-in 0 gives sum 16'h0000 and carry-out 1. Likewise, 16'h00FF + 16'h0001 gives 16'h0100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| c_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| c_o | output | 1 | Carry out of bit 15 |
| grp_p_o | output | 1 | Whole-word group propagate |
| grp_g_o | output | 1 | Whole-word group generate |

## Verification
All four results are combinational. Each one is due in the same clock period in which the operands and carry-in are applied, with zero register stages in between. The bench changes inputs on the falling edge. It then compares the sum, carry-out and both group terms against a behavioural 17-bit integer model one nanosecond after the following rising edge. By then the inputs have been stable for half a period. The stimulus covers the full-length carry chains, slice-boundary carries, the all-propagate case with and without carry-in, and a long stretch of pseudo-random operands.

// File: rtl/cla_pkg.sv
package cla_pkg;
  // generate/propagate pair for one bit or one group
  typedef struct packed {
    logic p;
    logic g;
  } pg_pair_t;

  localparam int unsigned DEF_SLICE_W    = 4;
  localparam int unsigned DEF_NUM_SLICES = 4;
endpackage

// File: rtl/cla_bit_pg.sv
module cla_bit_pg
  import cla_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  output pg_pair_t [W-1:0] pg_o
);
  for (genvar gi = 0; gi < W; gi++) begin : g_bit
    assign pg_o[gi].p = a_i[gi] ^ b_i[gi];
    assign pg_o[gi].g = a_i[gi] & b_i[gi];
  end
endmodule

// File: rtl/cla_lookahead.sv
// Flattened two-level lookahead: every carry is an OR of AND terms built
// directly from the generate/propagate inputs and the carry-in.
module cla_lookahead #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] p_i,
  input  logic [N-1:0] g_i,
  input  logic         cin_i,
  output logic [N:0]   carry_o,
  output logic         grp_p_o,
  output logic         grp_g_o
);
  logic [N-1:0] gen_only;
  logic [N-1:0] all_prop;
  logic         prod;
  logic         sop;

  always_comb begin
    gen_only = '0;
    all_prop = '0;
    prod     = 1'b0;
    sop      = 1'b0;
    for (int i = 0; i < N; i++) begin
      sop = 1'b0;
      for (int j = 0; j <= i; j++) begin
        prod = g_i[j];
        for (int k = j + 1; k <= i; k++) begin
          prod = prod & p_i[k];
        end
        sop = sop | prod;
      end
      gen_only[i] = sop;
      prod = 1'b1;
      for (int k = 0; k <= i; k++) begin
        prod = prod & p_i[k];
      end
      all_prop[i] = prod;
    end
  end

  assign carry_o[0] = cin_i;
  for (genvar gi = 0; gi < N; gi++) begin : g_carry
    assign carry_o[gi+1] = gen_only[gi] | (all_prop[gi] & cin_i);
  end

  assign grp_p_o = all_prop[N-1];
  assign grp_g_o = gen_only[N-1];
endmodule

// File: rtl/cla_slice.sv
module cla_slice
  import cla_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         grp_p_o,
  output logic         grp_g_o
);
  pg_pair_t [W-1:0] bit_pg;
  logic [W-1:0]     p_vec;
  logic [W-1:0]     g_vec;
  logic [W:0]       carry;

  cla_bit_pg #(.W(W)) u_pg (
    .a_i  (a_i),
    .b_i  (b_i),
    .pg_o (bit_pg)
  );

  for (genvar gi = 0; gi < W; gi++) begin : g_split
    assign p_vec[gi] = bit_pg[gi].p;
    assign g_vec[gi] = bit_pg[gi].g;
    assign sum_o[gi] = bit_pg[gi].p ^ carry[gi];
  end

  cla_lookahead #(.N(W)) u_la (
    .p_i     (p_vec),
    .g_i     (g_vec),
    .cin_i   (cin_i),
    .carry_o (carry),
    .grp_p_o (grp_p_o),
    .grp_g_o (grp_g_o)
  );
endmodule

// File: rtl/cla_adder16.sv
module cla_adder16
  import cla_pkg::*;
#(
  parameter  int unsigned SLICE_W    = DEF_SLICE_W,
  parameter  int unsigned NUM_SLICES = DEF_NUM_SLICES,
  localparam int unsigned WIDTH      = SLICE_W * NUM_SLICES
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             c_o,
  output logic             grp_p_o,
  output logic             grp_g_o
);
  logic [NUM_SLICES-1:0] slice_p;
  logic [NUM_SLICES-1:0] slice_g;
  logic [NUM_SLICES:0]   slice_cin;

  for (genvar gs = 0; gs < NUM_SLICES; gs++) begin : g_slice
    cla_slice #(.W(SLICE_W)) u_slice (
      .a_i     (a_i[gs*SLICE_W +: SLICE_W]),
      .b_i     (b_i[gs*SLICE_W +: SLICE_W]),
      .cin_i   (slice_cin[gs]),
      .sum_o   (sum_o[gs*SLICE_W +: SLICE_W]),
      .grp_p_o (slice_p[gs]),
      .grp_g_o (slice_g[gs])
    );
  end

  // second-level unit: same equations, group terms in place of bit terms
  cla_lookahead #(.N(NUM_SLICES)) u_top_la (
    .p_i     (slice_p),
    .g_i     (slice_g),
    .cin_i   (c_i),
    .carry_o (slice_cin),
    .grp_p_o (grp_p_o),
    .grp_g_o (grp_g_o)
  );

  assign c_o = slice_cin[NUM_SLICES];
endmodule

// File: rtl/cla_adder16_chk.sv
module cla_adder16_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             c_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             c_o,
  input logic             grp_p_o,
  input logic             grp_g_o
);
  logic [WIDTH:0] ref_full;
  logic [WIDTH:0] ref_nocin;

  assign ref_full  = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, c_i};
  assign ref_nocin = {1'b0, a_i} + {1'b0, b_i};

  always_comb begin
    if (!$isunknown({a_i, b_i, c_i})) begin
      AST_SUM_BITS: assert (sum_o == ref_full[WIDTH-1:0]);            // R1
      AST_CARRY_OUT: assert (c_o == ref_full[WIDTH]);                 // R2
      AST_GRP_PROP: assert (grp_p_o == (&(a_i ^ b_i)));               // R3
      AST_GRP_GEN: assert (grp_g_o == ref_nocin[WIDTH]);              // R4
      AST_COUT_FROM_PG: assert (c_o == (grp_g_o | (grp_p_o & c_i)));  // R5
      AST_PG_EXCLUSIVE: assert (!(grp_p_o && grp_g_o));               // R6
    end
  end
endmodule

bind cla_adder16 cla_adder16_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i     (a_i),
  .b_i     (b_i),
  .c_i     (c_i),
  .sum_o   (sum_o),
  .c_o     (c_o),
  .grp_p_o (grp_p_o),
  .grp_g_o (grp_g_o)
);

// File: tb/tb_cla_adder16.sv
`timescale 1ns/1ps
module tb_cla_adder16;
  logic        clk;
  logic        rst_n;
  logic [15:0] a_i;
  logic [15:0] b_i;
  logic        c_i;
  logic [15:0] sum_o;
  logic        c_o;
  logic        grp_p_o;
  logic        grp_g_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done     = 1'b0;

  cla_adder16 dut (
    .a_i     (a_i),
    .b_i     (b_i),
    .c_i     (c_i),
    .sum_o   (sum_o),
    .c_o     (c_o),
    .grp_p_o (grp_p_o),
    .grp_g_o (grp_g_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h (a=%h b=%h cin=%0d)",
               tag, act, exp, a_i, b_i, c_i);
    end
  endtask

  // apply on falling edge, compare just after the next rising edge
  task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic cin);
    int unsigned full;
    int unsigned nocin;
    bit          allp;
    @(negedge clk);
    a_i = a;
    b_i = b;
    c_i = cin;
    @(posedge clk);
    #1;
    full  = int'(a) + int'(b) + int'(cin);
    nocin = int'(a) + int'(b);
    allp  = ((a ^ b) == 16'hFFFF);
    check("R1 sum", int'(sum_o), int'(full & 32'hFFFF));
    check("R2 carry-out", int'(c_o), int'((full >> 16) & 1));
    check("R3 group propagate", int'(grp_p_o), int'(allp));
    check("R4 group generate", int'(grp_g_o), int'((nocin >> 16) & 1));
    check("R5 carry from group terms", int'(c_o),
          int'(((nocin >> 16) & 1) | (allp & cin)));
    check("R6 group terms exclusive", int'(grp_p_o & grp_g_o), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    a_i = '0;
    b_i = '0;
    c_i = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 idle sum", int'(sum_o), 0);
    check("R2 idle carry", int'(c_o), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R7: full-length propagate chains with carry-in
    apply(16'hFFFF, 16'h0000, 1'b1);
    check("R7 chain sum", int'(sum_o), 0);
    check("R7 chain carry", int'(c_o), 1);
    apply(16'hAAAA, 16'h5555, 1'b1);
    check("R7 alternating sum", int'(sum_o), 0);
    check("R7 alternating carry", int'(c_o), 1);
    apply(16'hAAAA, 16'h5555, 1'b0);
    // R8: generated carry crossing slice boundaries
    apply(16'hFFFF, 16'h0001, 1'b0);
    check("R8 ones plus one sum", int'(sum_o), 0);
    check("R8 ones plus one carry", int'(c_o), 1);
    apply(16'h00FF, 16'h0001, 1'b0);
    check("R8 two-slice carry", int'(sum_o), 16'h0100);
    apply(16'h0FFF, 16'h0000, 1'b1);
    check("R8 three-slice carry", int'(sum_o), 16'h1000);
    apply(16'h000F, 16'h0001, 1'b0);
    apply(16'h8000, 16'h8000, 1'b0);
    apply(16'hFFFF, 16'hFFFF, 1'b1);
    apply(16'h0000, 16'h0000, 1'b1);
    apply(16'h7FFF, 16'h0001, 1'b0);
    apply(16'h0F0F, 16'h00F1, 1'b1);

    for (int i = 0; i < 3000; i++) begin
      apply(16'($urandom), 16'($urandom), 1'($urandom));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule